// File: doc/BRIEF.md
# TDM Multichannel Element Selection Unit

This unit sits beside the serializer of a frame-based serial port that carries several elements (time slots) per frame. A boundary strobe marks the start of each element; when the frame sync accompanies the strobe, a new frame begins at element 0. The unit tracks the current element internally and, using per-element receive and transmit enable masks plus two small mode fields, decides three things for every element. It decides whether the transmit holding word moves into the transmit shift register. It decides whether the serial data output is driven or left high-impedance. It decides whether a word finished by the receiver is accepted into the receive holding register.

In the symmetric transmit mode, the transmit copy follows the receive selection, while output driving is gated by the transmit mask. The transmit ready pulses, and therefore the transmit interrupt count, track the receive selection, not the transmit mask. The transmit and receive pulses are counted per frame. A missed reload of the transmit holding register sets a sticky underflow flag, and the previous word goes out again.

Top module: `tdm_slot_select`

## Requirements
- R1: A strobe with `frame_sync` high makes element 0 active. A strobe without it advances the element index by one. A strobe during the last element (index NUM_ELEM-1) ends the frame (`elem_active` low, index held). Strobes outside a frame change nothing.
- R2: Mask bit k belongs to element k. A pulse on `rx_done` during an active element copies `rx_word` into `rx_hold`, sets `rx_ready` and pulses `rx_irq` for one cycle, but only when `rx_mode` is 00 or the receive mask bit of the current element is 1. `rx_rd` clears `rx_ready`.
- R3: With `tx_mode` 00, every element of the frame copies the holding word to the shift register and drives the output.
- R4: With `tx_mode` 01 or 11, only elements whose transmit mask bit is 1 copy and drive.
- R5: With `tx_mode` 10 (symmetric), every receive-selected element copies, whatever its transmit mask bit. The output is driven only where the transmit mask bit is 1 and the element is also receive-selected.
- R6: `dx_oe` is low whenever no element is active.
- R7: Each copy pulses `tx_irq` for one cycle after the strobe and sets `tx_ready`. A write on `tx_wr` loads the holding register and clears `tx_ready`.
- R8: `tx_irq_cnt` and `rx_irq_cnt` count the `tx_irq` and `rx_irq` pulses since the last frame start and clear at each frame start. The transmit count never exceeds NUM_ELEM.
- R9: A copy taken while `tx_ready` is high sets `tx_underflow`, which stays set until reset. The shift register then receives the holding word unchanged, which is the previously sent word.
- R10: Reset clears both masks and sets both modes to 00, drives `dx_oe` low, clears the element index, `elem_active`, `rx_ready`, the counters and the underflow flag, and leaves `tx_ready` high with a zero holding word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads the four configuration fields |
| cfg_rx_mode | input | 2 | Receive selection mode (00 = accept all) |
| cfg_tx_mode | input | 2 | Transmit selection mode |
| cfg_rx_mask | input | NUM_ELEM | Receive element enable mask |
| cfg_tx_mask | input | NUM_ELEM | Transmit element enable mask |
| frame_sync | input | 1 | Frame start, qualified by elem_strobe |
| elem_strobe | input | 1 | Element boundary strobe |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_wdata | input | WORD_W | Transmit holding write data |
| rx_done | input | 1 | Receiver finished a word |
| rx_word | input | WORD_W | Word from the receive shifter |
| rx_rd | input | 1 | Receive holding read acknowledge |
| elem_idx | output | IDX_W | Current element index |
| elem_active | output | 1 | An element of the frame is in progress |
| tx_shift | output | WORD_W | Transmit shift register load value |
| tx_ready | output | 1 | Transmit holding register empty |
| tx_irq | output | 1 | One-cycle pulse per holding-to-shift copy |
| tx_underflow | output | 1 | Sticky missed-reload flag |
| dx_oe | output | 1 | Serial output drive enable (low = high-impedance) |
| rx_hold | output | WORD_W | Receive holding register |
| rx_ready | output | 1 | Receive holding register full |
| rx_irq | output | 1 | One-cycle pulse per accepted receive word |
| tx_irq_cnt | output | CNT_W | Transmit pulses in the current frame |
| rx_irq_cnt | output | CNT_W | Receive pulses in the current frame |

## Verification
The main selection logic is swept over every pair of 4-bit receive and transmit masks under all four transmit modes and all four receive modes. Each element is checked for drive enable, shift contents, irq pulse and receive acceptance. Frames where the transmit mask is wider than the receive mask separate the symmetric mode from the plain masked mode, since only the symmetric mode drops drive on those elements while still copying on receive-only elements. A separate run after reset skips holding writes to expose the underflow flag and the re-sent word, and confirms that the reset defaults select every element.

// File: rtl/tdm_slot_pkg.sv
package tdm_slot_pkg;

  typedef enum logic [1:0] {
    TXM_ALL     = 2'b00,
    TXM_MASKED  = 2'b01,
    TXM_SYMM    = 2'b10,
    TXM_MASKED2 = 2'b11
  } tx_mode_e;

  localparam logic [1:0] RXM_ALL = 2'b00;

  typedef struct packed {
    logic copy;
    logic drive;
  } tx_slot_t;

endpackage

// File: rtl/tdm_slot_tracker.sv
module tdm_slot_tracker #(
  parameter int NUM_ELEM = 4,
  parameter int IDX_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_sync,
  input  logic             elem_strobe,
  output logic [IDX_W-1:0] idx_q,
  output logic             active_q,
  output logic [IDX_W-1:0] idx_d,
  output logic             active_d,
  output logic             frame_start
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ELEM - 1);

  assign frame_start = elem_strobe & frame_sync;

  always_comb begin
    idx_d    = idx_q;
    active_d = active_q;
    if (elem_strobe) begin
      if (frame_sync) begin
        idx_d    = '0;
        active_d = 1'b1;
      end else if (active_q) begin
        if (idx_q == LAST_IDX) begin
          active_d = 1'b0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      active_q <= 1'b0;
    end else if (elem_strobe) begin
      idx_q    <= idx_d;
      active_q <= active_d;
    end
  end

endmodule

// File: rtl/tdm_slot_decide.sv
module tdm_slot_decide
  import tdm_slot_pkg::*;
#(
  parameter int NUM_ELEM = 4,
  parameter int IDX_W    = 2
) (
  input  tx_mode_e            tx_mode,
  input  logic [1:0]          rx_mode,
  input  logic [NUM_ELEM-1:0] rx_mask,
  input  logic [NUM_ELEM-1:0] tx_mask,
  input  logic [IDX_W-1:0]    tx_idx,
  input  logic                tx_active,
  input  logic [IDX_W-1:0]    rx_idx,
  input  logic                rx_active,
  output tx_slot_t            tx_slot,
  output logic                rx_accept
);
  logic [NUM_ELEM-1:0] rx_vec;
  logic [NUM_ELEM-1:0] copy_vec;
  logic [NUM_ELEM-1:0] drive_vec;

  for (genvar k = 0; k < NUM_ELEM; k++) begin : g_elem
    assign rx_vec[k]    = (rx_mode == RXM_ALL) | rx_mask[k];
    assign copy_vec[k]  = (tx_mode == TXM_ALL)  ? 1'b1 :
                          (tx_mode == TXM_SYMM) ? rx_vec[k] : tx_mask[k];
    assign drive_vec[k] = (tx_mode == TXM_ALL)  ? 1'b1 :
                          (tx_mode == TXM_SYMM) ? (tx_mask[k] & rx_vec[k]) : tx_mask[k];
  end

  always_comb begin
    tx_slot.copy  = tx_active & copy_vec[tx_idx];
    tx_slot.drive = tx_active & drive_vec[tx_idx];
    rx_accept     = rx_active & rx_vec[rx_idx];
  end

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              strobe,
  input  logic              copy,
  input  logic              drive,
  output logic [WORD_W-1:0] shift_q,
  output logic              ready,
  output logic              irq_q,
  output logic              underflow_q,
  output logic              oe_q
);
  logic [WORD_W-1:0] hold_q, hold_d, shift_d;
  logic              full_q, full_d, irq_d, underflow_d, oe_d;

  assign ready = ~full_q;

  always_comb begin
    hold_d      = hold_q;
    full_d      = full_q;
    shift_d     = shift_q;
    irq_d       = 1'b0;
    underflow_d = underflow_q;
    oe_d        = oe_q;
    if (strobe) begin
      oe_d = drive;
    end
    if (copy) begin
      shift_d = hold_q;
      irq_d   = 1'b1;
      full_d  = 1'b0;
      if (!full_q) begin
        underflow_d = 1'b1;
      end
    end
    if (wr) begin
      hold_d = wdata;
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q      <= '0;
      full_q      <= 1'b0;
      shift_q     <= '0;
      irq_q       <= 1'b0;
      underflow_q <= 1'b0;
      oe_q        <= 1'b0;
    end else begin
      hold_q      <= hold_d;
      full_q      <= full_d;
      shift_q     <= shift_d;
      irq_q       <= irq_d;
      underflow_q <= underflow_d;
      oe_q        <= oe_d;
    end
  end

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              accept,
  input  logic [WORD_W-1:0] word,
  input  logic              rd,
  output logic [WORD_W-1:0] hold_q,
  output logic              ready_q,
  output logic              irq_q
);
  logic [WORD_W-1:0] hold_d;
  logic              ready_d, irq_d, take;

  assign take = done & accept;

  always_comb begin
    hold_d  = hold_q;
    ready_d = ready_q;
    irq_d   = 1'b0;
    if (rd) begin
      ready_d = 1'b0;
    end
    if (take) begin
      hold_d  = word;
      ready_d = 1'b1;
      irq_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      ready_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      ready_q <= ready_d;
      irq_q   <= irq_d;
    end
  end

endmodule

// File: rtl/tdm_event_cnt.sv
module tdm_event_cnt #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] base, cnt_d;
  logic             en;

  assign en = clr | inc;

  always_comb begin
    base  = clr ? '0 : cnt_q;
    cnt_d = base;
    if (inc && base != CNT_MAX) begin
      cnt_d = base + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/tdm_slot_select.sv
module tdm_slot_select
  import tdm_slot_pkg::*;
#(
  parameter  int NUM_ELEM = 4,
  parameter  int WORD_W   = 16,
  localparam int IDX_W    = (NUM_ELEM > 1) ? $clog2(NUM_ELEM) : 1,
  localparam int CNT_W    = $clog2(NUM_ELEM + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_rx_mode,
  input  logic [1:0]          cfg_tx_mode,
  input  logic [NUM_ELEM-1:0] cfg_rx_mask,
  input  logic [NUM_ELEM-1:0] cfg_tx_mask,
  input  logic                frame_sync,
  input  logic                elem_strobe,
  input  logic                tx_wr,
  input  logic [WORD_W-1:0]   tx_wdata,
  input  logic                rx_done,
  input  logic [WORD_W-1:0]   rx_word,
  input  logic                rx_rd,
  output logic [IDX_W-1:0]    elem_idx,
  output logic                elem_active,
  output logic [WORD_W-1:0]   tx_shift,
  output logic                tx_ready,
  output logic                tx_irq,
  output logic                tx_underflow,
  output logic                dx_oe,
  output logic [WORD_W-1:0]   rx_hold,
  output logic                rx_ready,
  output logic                rx_irq,
  output logic [CNT_W-1:0]    tx_irq_cnt,
  output logic [CNT_W-1:0]    rx_irq_cnt
);
  tx_mode_e            tx_mode_q;
  logic [1:0]          rx_mode_q;
  logic [NUM_ELEM-1:0] rx_mask_q, tx_mask_q;

  logic [IDX_W-1:0] idx_d;
  logic             active_d, frame_start;
  tx_slot_t         tx_slot;
  logic             rx_accept, tx_copy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_mode_q <= TXM_ALL;
      rx_mode_q <= RXM_ALL;
      rx_mask_q <= '0;
      tx_mask_q <= '0;
    end else if (cfg_we) begin
      tx_mode_q <= tx_mode_e'(cfg_tx_mode);
      rx_mode_q <= cfg_rx_mode;
      rx_mask_q <= cfg_rx_mask;
      tx_mask_q <= cfg_tx_mask;
    end
  end

  tdm_slot_tracker #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) u_tracker (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_sync  (frame_sync),
    .elem_strobe (elem_strobe),
    .idx_q       (elem_idx),
    .active_q    (elem_active),
    .idx_d       (idx_d),
    .active_d    (active_d),
    .frame_start (frame_start)
  );

  tdm_slot_decide #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W)) u_decide (
    .tx_mode   (tx_mode_q),
    .rx_mode   (rx_mode_q),
    .rx_mask   (rx_mask_q),
    .tx_mask   (tx_mask_q),
    .tx_idx    (idx_d),
    .tx_active (active_d),
    .rx_idx    (elem_idx),
    .rx_active (elem_active),
    .tx_slot   (tx_slot),
    .rx_accept (rx_accept)
  );

  assign tx_copy = elem_strobe & tx_slot.copy;

  tdm_tx_path #(.WORD_W(WORD_W)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr          (tx_wr),
    .wdata       (tx_wdata),
    .strobe      (elem_strobe),
    .copy        (tx_copy),
    .drive       (tx_slot.drive),
    .shift_q     (tx_shift),
    .ready       (tx_ready),
    .irq_q       (tx_irq),
    .underflow_q (tx_underflow),
    .oe_q        (dx_oe)
  );

  tdm_rx_path #(.WORD_W(WORD_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .done    (rx_done),
    .accept  (rx_accept),
    .word    (rx_word),
    .rd      (rx_rd),
    .hold_q  (rx_hold),
    .ready_q (rx_ready),
    .irq_q   (rx_irq)
  );

  tdm_event_cnt #(.CNT_W(CNT_W)) u_tx_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_start),
    .inc   (tx_irq),
    .cnt_q (tx_irq_cnt)
  );

  tdm_event_cnt #(.CNT_W(CNT_W)) u_rx_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (frame_start),
    .inc   (rx_irq),
    .cnt_q (rx_irq_cnt)
  );

endmodule

// File: rtl/tdm_slot_select_checker.sv
module tdm_slot_select_checker #(
  parameter int NUM_ELEM = 4,
  parameter int IDX_W    = 2,
  parameter int CNT_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             elem_strobe,
  input logic             frame_sync,
  input logic [IDX_W-1:0] elem_idx,
  input logic             elem_active,
  input logic             dx_oe,
  input logic             tx_irq,
  input logic             tx_underflow,
  input logic             rx_irq,
  input logic             rx_ready,
  input logic [CNT_W-1:0] tx_irq_cnt
);
  assert_oe_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !elem_active |-> !dx_oe);

  assert_idx_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    elem_active |-> (elem_idx <= IDX_W'(NUM_ELEM - 1)));

  assert_frame_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_strobe && frame_sync) |=> (elem_active && elem_idx == '0));

  assert_rx_irq_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> rx_ready);

  assert_tx_irq_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(elem_strobe));

  assert_tx_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq_cnt <= CNT_W'(NUM_ELEM));

  assert_underflow_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_underflow |=> tx_underflow);

  assert_underflow_on_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_underflow) |-> tx_irq);

endmodule

bind tdm_slot_select tdm_slot_select_checker #(
  .NUM_ELEM (NUM_ELEM),
  .IDX_W    (IDX_W),
  .CNT_W    (CNT_W)
) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .elem_strobe  (elem_strobe),
  .frame_sync   (frame_sync),
  .elem_idx     (elem_idx),
  .elem_active  (elem_active),
  .dx_oe        (dx_oe),
  .tx_irq       (tx_irq),
  .tx_underflow (tx_underflow),
  .rx_irq       (rx_irq),
  .rx_ready     (rx_ready),
  .tx_irq_cnt   (tx_irq_cnt)
);

// File: tb/tdm_slot_select_bench.sv
module tdm_slot_select_bench;
  localparam int N     = 4;
  localparam int W     = 16;
  localparam int IDX_W = 2;
  localparam int CNT_W = 3;

  logic clk, rst_n;
  logic cfg_we;
  logic [1:0] cfg_rx_mode, cfg_tx_mode;
  logic [N-1:0] cfg_rx_mask, cfg_tx_mask;
  logic frame_sync, elem_strobe, tx_wr, rx_done, rx_rd;
  logic [W-1:0] tx_wdata, rx_word;
  logic [IDX_W-1:0] elem_idx;
  logic elem_active, tx_ready, tx_irq, tx_underflow, dx_oe, rx_ready, rx_irq;
  logic [W-1:0] tx_shift, rx_hold;
  logic [CNT_W-1:0] tx_irq_cnt, rx_irq_cnt;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  tdm_slot_select #(.NUM_ELEM(N), .WORD_W(W)) u_tdm_slot_select (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_rx_mode(cfg_rx_mode),
    .cfg_tx_mode(cfg_tx_mode), .cfg_rx_mask(cfg_rx_mask), .cfg_tx_mask(cfg_tx_mask),
    .frame_sync(frame_sync), .elem_strobe(elem_strobe), .tx_wr(tx_wr),
    .tx_wdata(tx_wdata), .rx_done(rx_done), .rx_word(rx_word), .rx_rd(rx_rd),
    .elem_idx(elem_idx), .elem_active(elem_active), .tx_shift(tx_shift),
    .tx_ready(tx_ready), .tx_irq(tx_irq), .tx_underflow(tx_underflow),
    .dx_oe(dx_oe), .rx_hold(rx_hold), .rx_ready(rx_ready), .rx_irq(rx_irq),
    .tx_irq_cnt(tx_irq_cnt), .rx_irq_cnt(rx_irq_cnt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit rx_sel_f(input int rxm, input logic [N-1:0] rmask, input int k);
    return (rxm == 0) || rmask[k];
  endfunction

  function automatic bit copy_f(input int txm, input int rxm, input logic [N-1:0] rmask,
                                input logic [N-1:0] tmask, input int k);
    if (txm == 0) return 1'b1;
    if (txm == 2) return rx_sel_f(rxm, rmask, k);
    return tmask[k];
  endfunction

  function automatic bit drive_f(input int txm, input int rxm, input logic [N-1:0] rmask,
                                 input logic [N-1:0] tmask, input int k);
    if (txm == 0) return 1'b1;
    if (txm == 2) return tmask[k] && rx_sel_f(rxm, rmask, k);
    return tmask[k];
  endfunction

  function automatic string tx_req(input int txm);
    if (txm == 0) return "R3";
    if (txm == 2) return "R5";
    return "R4";
  endfunction

  logic [W-1:0] exp_shift;
  logic [W-1:0] exp_rx;

  task automatic run_frame(input int rxm, input int txm, input logic [N-1:0] rmask,
                           input logic [N-1:0] tmask, input int fnum);
    int n_copy = 0;
    int n_rx   = 0;
    cfg_we = 1'b1; cfg_rx_mode = 2'(rxm); cfg_tx_mode = 2'(txm);
    cfg_rx_mask = rmask; cfg_tx_mask = tmask;
    tick();
    cfg_we = 1'b0;
    for (int k = 0; k < N; k++) begin
      logic [W-1:0] wv;
      bit c, d, s;
      wv = W'((fnum << 4) | k);
      c = copy_f(txm, rxm, rmask, tmask, k);
      d = drive_f(txm, rxm, rmask, tmask, k);
      s = rx_sel_f(rxm, rmask, k);
      tx_wr = 1'b1; tx_wdata = wv;
      tick();
      tx_wr = 1'b0; elem_strobe = 1'b1; frame_sync = (k == 0);
      tick();
      elem_strobe = 1'b0; frame_sync = 1'b0;
      if (c) begin
        exp_shift = wv;
        n_copy++;
      end
      check("R1", "elem_idx", int'(elem_idx), k);
      check(tx_req(txm), "dx_oe", int'(dx_oe), int'(d));
      check(tx_req(txm), "tx_shift", int'(tx_shift), int'(exp_shift));
      check("R7", "tx_irq", int'(tx_irq), int'(c));
      rx_done = 1'b1; rx_word = wv ^ 16'hA5A5;
      tick();
      rx_done = 1'b0;
      if (s) begin
        exp_rx = wv ^ 16'hA5A5;
        n_rx++;
      end
      check("R2", "rx_ready", int'(rx_ready), int'(s));
      check("R2", "rx_irq", int'(rx_irq), int'(s));
      check("R2", "rx_hold", int'(rx_hold), int'(exp_rx));
      rx_rd = 1'b1;
      tick();
      rx_rd = 1'b0;
      check("R2", "rx_ready after read", int'(rx_ready), 0);
    end
    elem_strobe = 1'b1;
    tick();
    elem_strobe = 1'b0;
    check("R1", "elem_active after last", int'(elem_active), 0);
    check("R6", "dx_oe outside frame", int'(dx_oe), 0);
    check("R8", "tx_irq_cnt", int'(tx_irq_cnt), n_copy);
    check("R8", "rx_irq_cnt", int'(rx_irq_cnt), n_rx);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_rx_mode = '0; cfg_tx_mode = '0;
    cfg_rx_mask = '0; cfg_tx_mask = '0; frame_sync = 1'b0; elem_strobe = 1'b0;
    tx_wr = 1'b0; tx_wdata = '0; rx_done = 1'b0; rx_word = '0; rx_rd = 1'b0;
    exp_shift = '0; exp_rx = '0;
    do_reset();

    // R10: reset state at the ports
    check("R10", "dx_oe", int'(dx_oe), 0);
    check("R10", "elem_active", int'(elem_active), 0);
    check("R10", "elem_idx", int'(elem_idx), 0);
    check("R10", "tx_ready", int'(tx_ready), 1);
    check("R10", "rx_ready", int'(rx_ready), 0);
    check("R10", "tx_underflow", int'(tx_underflow), 0);
    check("R10", "tx_irq_cnt", int'(tx_irq_cnt), 0);
    check("R10", "rx_irq_cnt", int'(rx_irq_cnt), 0);

    // R9 / R10: default modes select all; copy without reload underflows
    elem_strobe = 1'b1; frame_sync = 1'b1;
    tick();
    elem_strobe = 1'b0; frame_sync = 1'b0;
    check("R10", "default drive", int'(dx_oe), 1);
    check("R9", "underflow set", int'(tx_underflow), 1);
    check("R9", "shift after empty copy", int'(tx_shift), 0);
    rx_done = 1'b1; rx_word = 16'h0F0F;
    tick();
    rx_done = 1'b0;
    check("R10", "default rx accept", int'(rx_ready), 1);
    tx_wr = 1'b1; tx_wdata = 16'h1234;
    tick();
    tx_wr = 1'b0;
    check("R7", "tx_ready after write", int'(tx_ready), 0);
    elem_strobe = 1'b1;
    tick();
    elem_strobe = 1'b0;
    check("R9", "shift after reload", int'(tx_shift), 16'h1234);
    check("R7", "tx_ready after copy", int'(tx_ready), 1);
    check("R9", "underflow sticky", int'(tx_underflow), 1);
    elem_strobe = 1'b1;
    tick();
    elem_strobe = 1'b0;
    check("R9", "resend previous word", int'(tx_shift), 16'h1234);
    check("R1", "index advance", int'(elem_idx), 2);

    // Sweep of modes and masks
    do_reset();
    exp_shift = '0; exp_rx = '0;
    begin
      int fnum = 0;
      for (int rxm = 0; rxm < 4; rxm++)
        for (int txm = 0; txm < 4; txm++)
          for (int rm = 0; rm < 16; rm++)
            for (int tm = 0; tm < 16; tm++) begin
              run_frame(rxm, txm, N'(rm), N'(tm), fnum);
              fnum++;
            end
    end
    check("R9", "no underflow when reloaded", int'(tx_underflow), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule